// File: doc/BRIEF.md
# Addressing Side-Effect Backup Tracker

This block keeps track of how general registers are changed while one instruction executes, so that an instruction stopped by a memory fault can be restarted cleanly. The changes it tracks come from autoincrement and autodecrement addressing and from references through the program counter. At the start of each instruction it captures the instruction word. From that word it decodes how many operands the instruction has and which of those operands can change a register. While the instruction runs, the execution unit reports each register update as a register number with a signed step.

When the instruction is aborted, the record is frozen. The abort indication says whether the source operand or the destination operand faulted. From that indication and the decoded operands, the block works out which recorded changes must be undone. It emits those corrections as a valid/ready stream, and each correction carries the register and the amount to add to it. The undo logic downstream may apply back-pressure by holding `corr_ready` low. While it does, the offered correction stays unchanged. The record stays readable at the ports until software acknowledges it.

Register update events also arrive on a valid/ready handshake. `upd_ready` is low while the record is frozen, so an update is only ever stalled and is never lost. Instruction start, abort and acknowledge are plain single-cycle pulses.

Top module: `asfx_tracker`

## Requirements
- R1: Operand count (`op_count`: 0, 1 or 2) is decoded from the latched word. Bits 15-12 with a low three-bit value of 1..6 give two operands: the source field is bits 11-6 and the destination field is bits 5-0. Bits 15-12 equal to 0111 give one operand. When bits 15-12 are 0000 or 1000, bits 11-9 decide the count: 101 or 110 give one operand, 100 gives one operand only for 0000, and 000 gives one operand when bits 8-6 are 001 or 011; every other value gives none. When bits 15-12 are 1111, the count is one, except that when bits 15-9 are 1111000 and bits 8-6 are 000 it is zero. A single operand is always the destination field.
- R2: An operand field (mode in its bits 5-3, register in its bits 2-0) can change a register when its mode is 2, 3, 4 or 5 with any register, or when its mode is 6 or 7 with register 7 (the program counter).
- R3: A `start_valid` pulse while not frozen clears the record and latches `instr_word`. While frozen, the pulse is ignored.
- R4: An accepted update adds its 5-bit two's-complement delta to the entry for the same register, wrapping at 5 bits. If there is no entry for that register, the update fills the first free entry of two. An update for a third register is dropped.
- R5: An `abort_valid` pulse while not frozen freezes the record. While frozen, `upd_ready` is low and further aborts are ignored.
- R6: When only one operand can change a register, that operand is corrected whichever operand the abort names.
- R7: When both operands can change registers, a source abort (`abort_dst`=0) corrects only the source register and a destination abort (`abort_dst`=1) corrects both.
- R8: When both operands can change the same register, `conflict` is high and an abort produces no corrections.
- R9: Corrections are offered in record-entry order and only for selected registers that have an entry. Each carries `corr_amount` equal to the negated recorded delta, and `corr_last` marks the final one. A correction offered while `corr_ready` is low holds its value.
- R10: A `rec_ack` pulse releases the freeze only when no correction is pending. While a correction is pending, the pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| start_valid | input | 1 | instruction start pulse |
| instr_word | input | 16 | instruction word, latched at start |
| upd_valid | input | 1 | register update offered |
| upd_ready | output | 1 | update accepted (low while frozen) |
| upd_reg | input | 3 | updated register number |
| upd_delta | input | 5 | signed step applied to that register |
| abort_valid | input | 1 | instruction aborted |
| abort_dst | input | 1 | 1: destination operand faulted, 0: source |
| rec_ack | input | 1 | record has been read, release freeze |
| rec_frozen | output | 1 | record frozen by an abort |
| rec_count | output | 2 | number of valid entries |
| rec0_reg | output | 3 | entry 0 register |
| rec0_delta | output | 5 | entry 0 accumulated delta |
| rec1_reg | output | 3 | entry 1 register |
| rec1_delta | output | 5 | entry 1 accumulated delta |
| op_count | output | 2 | decoded operand count |
| conflict | output | 1 | same register changed by both operands |
| corr_valid | output | 1 | correction offered |
| corr_ready | input | 1 | correction taken |
| corr_reg | output | 3 | register to correct |
| corr_amount | output | 5 | signed amount to add |
| corr_last | output | 1 | final correction of this abort |

## Verification
The assertions check several rules on every cycle. No update is accepted while the record is frozen. The record never holds more than two entries. Corrections appear only while frozen and never under a conflict. An offered correction holds still under back-pressure. The freeze ends only on an acknowledge with nothing pending. Only the directed scenarios can show that the opcode decode gives the right operand count, and that the source and destination fault rules pick the right registers. They also show that the amounts are the exact negation of the accumulated steps and that a third register is dropped.

// File: rtl/asfx_pkg.sv
package asfx_pkg;
  localparam int WORD_W  = 16;
  localparam int REG_W   = 3;
  localparam int DELTA_W = 5;
  localparam int ENTRIES = 2;
  localparam int CNT_W   = $clog2(ENTRIES + 1);
  localparam logic [REG_W-1:0] PC_REG = '1;

  typedef struct packed {
    logic               vld;
    logic [REG_W-1:0]   rnum;
    logic [DELTA_W-1:0] delta;
  } rec_entry_t;

  typedef rec_entry_t [ENTRIES-1:0] rec_set_t;
endpackage

// File: rtl/asfx_decode.sv
module asfx_decode
  import asfx_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [1:0]        op_count,
  output logic              se_src,
  output logic              se_dst,
  output logic [REG_W-1:0]  src_reg,
  output logic [REG_W-1:0]  dst_reg,
  output logic              conflict
);
  function automatic logic field_changes(input logic [5:0] f);
    logic [2:0] mode;
    mode = f[5:3];
    return (mode >= 3'd2 && mode <= 3'd5) || (f[2:0] == PC_REG && mode >= 3'd6);
  endfunction

  logic [3:0] top4;
  logic [2:0] mid3;
  logic [2:0] low3;

  always_comb begin
    top4 = word[15:12];
    mid3 = word[11:9];
    low3 = word[8:6];
    op_count = 2'd0;
    if (top4[2:0] >= 3'd1 && top4[2:0] <= 3'd6) begin
      op_count = 2'd2;
    end else if (top4 == 4'b0111) begin
      op_count = 2'd1;
    end else if (top4 == 4'b0000 || top4 == 4'b1000) begin
      if (mid3 == 3'b101 || mid3 == 3'b110) op_count = 2'd1;
      else if (mid3 == 3'b100 && top4 == 4'b0000) op_count = 2'd1;
      else if (mid3 == 3'b000 && (low3 == 3'b001 || low3 == 3'b011)) op_count = 2'd1;
    end else begin
      if (mid3 == 3'b000 && low3 == 3'b000) op_count = 2'd0;
      else op_count = 2'd1;
    end
    src_reg  = word[8:6];
    dst_reg  = word[2:0];
    se_src   = (op_count == 2'd2) && field_changes(word[11:6]);
    se_dst   = (op_count != 2'd0) && field_changes(word[5:0]);
    conflict = se_src && se_dst && (src_reg == dst_reg);
  end
endmodule

// File: rtl/asfx_record.sv
module asfx_record
  import asfx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               upd_fire,
  input  logic [REG_W-1:0]   upd_reg,
  input  logic [DELTA_W-1:0] upd_delta,
  output rec_set_t           rec,
  output logic [CNT_W-1:0]   count
);
  rec_set_t nxt;
  logic     placed;

  always_comb begin
    nxt = rec;
    if (clear) begin
      for (int i = 0; i < ENTRIES; i++) nxt[i] = '0;
    end
    placed = 1'b0;
    if (upd_fire) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!placed && nxt[i].vld && nxt[i].rnum == upd_reg) begin
          nxt[i].delta = nxt[i].delta + upd_delta;
          placed = 1'b1;
        end
      end
      for (int i = 0; i < ENTRIES; i++) begin
        if (!placed && !nxt[i].vld) begin
          nxt[i].vld   = 1'b1;
          nxt[i].rnum  = upd_reg;
          nxt[i].delta = upd_delta;
          placed = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rec <= '0;
    else        rec <= nxt;
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < ENTRIES; i++) count = count + CNT_W'(rec[i].vld);
  end
endmodule

// File: rtl/asfx_undo.sv
module asfx_undo
  import asfx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frozen,
  input  logic               arm,
  input  rec_set_t           rec,
  input  logic               se_src,
  input  logic               se_dst,
  input  logic               conflict,
  input  logic               abort_dst_q,
  input  logic [REG_W-1:0]   src_reg,
  input  logic [REG_W-1:0]   dst_reg,
  output logic               corr_valid,
  input  logic               corr_ready,
  output logic [REG_W-1:0]   corr_reg,
  output logic [DELTA_W-1:0] corr_amount,
  output logic               corr_last
);
  logic               src_on, dst_on;
  logic [ENTRIES-1:0] done, pend, pick;

  assign src_on = se_src && !conflict;
  assign dst_on = se_dst && !conflict && (abort_dst_q || !se_src);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_pend
    assign pend[g] = frozen && rec[g].vld && !done[g] &&
                     ((src_on && rec[g].rnum == src_reg) ||
                      (dst_on && rec[g].rnum == dst_reg));
  end

  always_comb begin
    pick        = '0;
    corr_reg    = '0;
    corr_amount = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pick        = '0;
        pick[i]     = 1'b1;
        corr_reg    = rec[i].rnum;
        corr_amount = -rec[i].delta;
      end
    end
    corr_valid = |pend;
    corr_last  = ($countones(pend) == 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        done <= '0;
    else if (arm)                      done <= '0;
    else if (corr_valid && corr_ready) done <= done | pick;
  end
endmodule

// File: rtl/asfx_tracker.sv
module asfx_tracker
  import asfx_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_valid,
  input  logic [15:0]  instr_word,
  input  logic         upd_valid,
  output logic         upd_ready,
  input  logic [2:0]   upd_reg,
  input  logic [4:0]   upd_delta,
  input  logic         abort_valid,
  input  logic         abort_dst,
  input  logic         rec_ack,
  output logic         rec_frozen,
  output logic [1:0]   rec_count,
  output logic [2:0]   rec0_reg,
  output logic [4:0]   rec0_delta,
  output logic [2:0]   rec1_reg,
  output logic [4:0]   rec1_delta,
  output logic [1:0]   op_count,
  output logic         conflict,
  output logic         corr_valid,
  input  logic         corr_ready,
  output logic [2:0]   corr_reg,
  output logic [4:0]   corr_amount,
  output logic         corr_last
);
  logic [WORD_W-1:0] instr_q;
  logic              frozen, abort_dst_q;
  logic              start_fire, abort_fire, ack_fire, upd_fire;
  logic              se_src, se_dst;
  logic [REG_W-1:0]  src_reg, dst_reg;
  rec_set_t          rec;
  logic [CNT_W-1:0]  count;

  assign upd_ready  = !frozen;
  assign upd_fire   = upd_valid && upd_ready;
  assign start_fire = start_valid && !frozen;
  assign abort_fire = abort_valid && !frozen;
  assign ack_fire   = rec_ack && frozen && !corr_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q     <= '0;
      frozen      <= 1'b0;
      abort_dst_q <= 1'b0;
    end else begin
      if (start_fire) instr_q <= instr_word;
      if (abort_fire) begin
        frozen      <= 1'b1;
        abort_dst_q <= abort_dst;
      end else if (ack_fire) begin
        frozen <= 1'b0;
      end
    end
  end

  asfx_decode u_decode (
    .word(instr_q), .op_count(op_count), .se_src(se_src), .se_dst(se_dst),
    .src_reg(src_reg), .dst_reg(dst_reg), .conflict(conflict)
  );

  asfx_record u_record (
    .clk(clk), .rst_n(rst_n), .clear(start_fire), .upd_fire(upd_fire),
    .upd_reg(upd_reg), .upd_delta(upd_delta), .rec(rec), .count(count)
  );

  asfx_undo u_undo (
    .clk(clk), .rst_n(rst_n), .frozen(frozen), .arm(abort_fire), .rec(rec),
    .se_src(se_src), .se_dst(se_dst), .conflict(conflict),
    .abort_dst_q(abort_dst_q), .src_reg(src_reg), .dst_reg(dst_reg),
    .corr_valid(corr_valid), .corr_ready(corr_ready), .corr_reg(corr_reg),
    .corr_amount(corr_amount), .corr_last(corr_last)
  );

  assign rec_frozen = frozen;
  assign rec_count  = count;
  assign rec0_reg   = rec[0].rnum;
  assign rec0_delta = rec[0].delta;
  assign rec1_reg   = rec[1].rnum;
  assign rec1_delta = rec[1].delta;
endmodule

// File: rtl/asfx_checker.sv
module asfx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_valid,
  input logic       upd_valid,
  input logic       upd_ready,
  input logic       rec_ack,
  input logic       rec_frozen,
  input logic [1:0] rec_count,
  input logic       conflict,
  input logic       corr_valid,
  input logic       corr_ready,
  input logic [2:0] corr_reg,
  input logic [4:0] corr_amount
);
  a_r5_no_update_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    rec_frozen |-> !upd_ready);

  a_r4_two_entries_max: assert property (@(posedge clk) disable iff (!rst_n)
    rec_count <= 2'd2);

  a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && !rec_frozen && !upd_valid) |=> (rec_count == 2'd0));

  a_r8_conflict_silent: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> !corr_valid);

  a_r9_only_when_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |-> rec_frozen);

  a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_valid && !corr_ready) |=> (corr_valid && $stable(corr_reg) && $stable(corr_amount)));

  a_r10_release_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_frozen && !(rec_ack && !corr_valid)) |=> rec_frozen);
endmodule

bind asfx_tracker asfx_checker u_asfx_checker (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .upd_valid(upd_valid),
  .upd_ready(upd_ready), .rec_ack(rec_ack), .rec_frozen(rec_frozen),
  .rec_count(rec_count), .conflict(conflict), .corr_valid(corr_valid),
  .corr_ready(corr_ready), .corr_reg(corr_reg), .corr_amount(corr_amount)
);

// File: tb/asfx_tracker_bench.sv
`timescale 1ns/1ps
module asfx_tracker_bench;
  logic clk = 0, rst_n = 0;
  logic start_valid = 0, upd_valid = 0, abort_valid = 0, abort_dst = 0;
  logic rec_ack = 0, corr_ready = 0;
  logic [15:0] instr_word = '0;
  logic [2:0] upd_reg = '0;
  logic [4:0] upd_delta = '0;
  logic upd_ready, rec_frozen, conflict, corr_valid, corr_last;
  logic [1:0] rec_count, op_count;
  logic [2:0] rec0_reg, rec1_reg, corr_reg;
  logic [4:0] rec0_delta, rec1_delta, corr_amount;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  asfx_tracker u_asfx_tracker (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic do_start(input logic [15:0] w);
    start_valid = 1; instr_word = w; tick(); start_valid = 0;
  endtask
  task automatic do_upd(input int r, input int d);
    upd_valid = 1; upd_reg = 3'(r); upd_delta = 5'(d); tick(); upd_valid = 0;
  endtask
  task automatic do_abort(input logic dst);
    abort_valid = 1; abort_dst = dst; tick(); abort_valid = 0;
  endtask
  task automatic do_ack(); rec_ack = 1; tick(); rec_ack = 0; endtask
  task automatic pop(input string tag, input int r, input int amt, input int last);
    chk({tag, " valid"}, int'(corr_valid), 1);
    chk({tag, " reg"}, int'(corr_reg), r);
    chk({tag, " amount"}, int'(corr_amount), amt & 31);
    chk({tag, " last"}, int'(corr_last), last);
    corr_ready = 1; tick(); corr_ready = 0;
  endtask

  task automatic t_reset();
    chk("R3 reset count", rec_count, 0);
    chk("R5 reset frozen", rec_frozen, 0);
    chk("R9 reset corr_valid", corr_valid, 0);
    chk("R5 reset upd_ready", upd_ready, 1);
  endtask

  task automatic t_decode();
    do_start(16'h14A3); chk("R1 two-operand", op_count, 2);
    do_start(16'h0A11); chk("R1 single group", op_count, 1);
    do_start(16'h0100); chk("R1 branch none", op_count, 0);
    do_start(16'hF000); chk("R1 float none", op_count, 0);
    do_start(16'hF040); chk("R1 float one", op_count, 1);
    do_start(16'h7011); chk("R1 0111 one", op_count, 1);
    do_start(16'h0840); chk("R1 0000/100 one", op_count, 1);
    do_start(16'h8840); chk("R1 1000/100 none", op_count, 0);
  endtask

  task automatic t_accumulate();
    do_start(16'h14A3);
    do_upd(2, 1); do_upd(2, 1); do_upd(3, -2);
    chk("R4 count", rec_count, 2);
    chk("R4 e0 reg", rec0_reg, 2);
    chk("R4 e0 delta", rec0_delta, 2);
    chk("R4 e1 reg", rec1_reg, 3);
    chk("R4 e1 delta", rec1_delta, 30);
    do_upd(5, 2);
    chk("R4 third dropped count", rec_count, 2);
    chk("R4 third dropped e1", rec1_reg, 3);
    do_start(16'h14A3);
    chk("R3 start clears", rec_count, 0);
  endtask

  task automatic t_src_abort();
    do_start(16'h14A3); do_upd(2, 2); do_abort(0);
    chk("R5 frozen", rec_frozen, 1);
    pop("R7 src only", 2, -2, 1);
    chk("R7 nothing more", corr_valid, 0);
    do_ack();
  endtask

  task automatic t_dst_abort();
    do_start(16'h14A3); do_upd(2, 2); do_upd(3, -2); do_abort(1);
    chk("R9 stall hold valid", corr_valid, 1);
    tick();
    chk("R9 stall hold reg", corr_reg, 2);
    do_ack();
    chk("R10 ack ignored while pending", rec_frozen, 1);
    do_start(16'h0100);
    chk("R3 start ignored frozen", op_count, 2);
    chk("R5 upd_ready low", upd_ready, 0);
    pop("R7 both first", 2, -2, 0);
    pop("R7 both second", 3, 2, 1);
    do_ack();
    chk("R10 released", rec_frozen, 0);
  endtask

  task automatic t_single();
    do_start(16'h1014); do_upd(4, 2); do_abort(0);
    pop("R6 single dst", 4, -2, 1);
    do_ack();
  endtask

  task automatic t_pc_ref();
    do_start(16'h1077); do_upd(7, 2); do_abort(0);
    pop("R2 pc index", 7, -2, 1);
    do_ack();
    do_start(16'h1000); do_upd(0, 2); do_abort(1);
    chk("R2 mode0 no correction", corr_valid, 0);
    do_ack();
  endtask

  task automatic t_conflict();
    do_start(16'h1451);
    chk("R8 conflict flag", conflict, 1);
    do_upd(1, 2); do_abort(1);
    chk("R8 no correction", corr_valid, 0);
    do_abort(0);
    chk("R8 frozen", rec_frozen, 1);
    do_ack();
    chk("R10 release empty", rec_frozen, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    t_reset();
    t_decode();
    t_accumulate();
    t_src_abort();
    t_dst_abort();
    t_single();
    t_pc_ref();
    t_conflict();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule